// File: doc/BRIEF.md
# PC-Relative Add and Register-Indirect Jump Unit

This block produces the architectural results of two 32-bit instructions whose answers depend on the program counter. The first adds a 20-bit upper immediate to the PC. The second is an indirect jump that also saves a return address. In both, the PC value used is the address of the instruction that is executing. It is never the already-advanced fetch address.

A thin single-cycle wrapper holds the program counter. Each cycle it presents the current address, takes in the instruction word fetched from that address and the value of the first source register, and returns the following:

- the destination register index, its write value and its write enable;
- the index of the source register to read;
- a redirect strobe with its target.

On the next clock the PC takes the redirect target if there is one, and otherwise the address four bytes on. Every other instruction encoding passes through as a plain sequential step. Decoding of those encodings is left to the surrounding core.

Top module: `pcj_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) loads the parameter `RESET_VEC` (default 0x0000_1000) into `pc_o`, and takes priority over any redirect in the same cycle.
- R2: An instruction with bits 6:0 = 7'b0010111 produces `rd_wdata_o` = `pc_o` + {instr[31:12], 12'b0}, computed from the address of that same instruction, and raises no redirect.
- R3: An instruction with bits 6:0 = 7'b1100111 and bits 14:12 = 3'b000 raises `redirect_o` with `target_o` = `rs1_val_i` + sign-extended instr[31:20], with bit 0 of the sum forced to 0. `rs1_idx_o` always equals instr[19:15].
- R4: The indirect jump of R3 produces `rd_wdata_o` = `pc_o` + 4.
- R5: `rd_idx_o` equals instr[11:7]. `rd_we_o` is high only for the instructions of R2 and R3, and only when that field is not zero.
- R6: On the clock after a cycle with `redirect_o` high, `pc_o` holds the previous `target_o`. After any other cycle outside reset it holds the previous `pc_o` + 4.
- R7: Any other encoding, including bits 6:0 = 7'b1100111 with bits 14:12 not zero, gives `rd_we_o` = 0 and `redirect_o` = 0.
- R8: When the destination index of the indirect jump equals its source index, the target is still computed from the `rs1_val_i` presented in that cycle.
- R9: All address sums wrap modulo 2^32, so a sequential step from 0xFFFF_FFFC leads to 0x0000_0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| instr_i | input | 32 | Instruction word fetched from `pc_o` |
| rs1_val_i | input | 32 | Value of the first source register |
| pc_o | output | 32 | Address of the executing instruction |
| rs1_idx_o | output | 5 | Index of the first source register |
| rd_idx_o | output | 5 | Destination register index |
| rd_wdata_o | output | 32 | Value to write to the destination register |
| rd_we_o | output | 1 | Destination write enable |
| redirect_o | output | 1 | A jump target replaces the sequential address |
| target_o | output | 32 | Jump target address |

## Verification
The assertions assume that `instr_i` and `rs1_val_i` carry defined values that are steady across each rising edge. They also assume that reset is sampled only at the clock. Without the first assumption the redirect and the next-PC checks would compare unknowns. The bench changes inputs only on the falling edge and drives defined words throughout, including the unused encodings. It steers the PC through a high jump so that the wrap-around, the odd-target case and the reset-over-redirect case are all reached.

// File: rtl/pcj_pkg.sv
package pcj_pkg;

  localparam int XLEN = 32;
  localparam int REGW = 5;
  localparam int UIMMW = 20;
  localparam int IIMMW = 12;

  localparam logic [6:0] OPC_UPPER_PC = 7'b0010111;
  localparam logic [6:0] OPC_IND_JUMP = 7'b1100111;
  localparam logic [2:0] F3_IND_JUMP  = 3'b000;

  typedef enum logic [1:0] {
    KIND_SEQ  = 2'd0,
    KIND_UPC  = 2'd1,
    KIND_JUMP = 2'd2
  } kind_e;

  typedef struct packed {
    kind_e             kind;
    logic [REGW-1:0]   rd;
    logic [REGW-1:0]   rs1;
    logic [UIMMW-1:0]  uimm;
    logic [IIMMW-1:0]  iimm;
  } fields_t;

  // Upper immediate placed above twelve zero bits.
  function automatic logic [XLEN-1:0] upper_offset(input logic [UIMMW-1:0] u);
    return {u, {(XLEN-UIMMW){1'b0}}};
  endfunction

  // Twelve-bit immediate sign-extended to the full width.
  function automatic logic [XLEN-1:0] sext_short(input logic [IIMMW-1:0] i);
    return {{(XLEN-IIMMW){i[IIMMW-1]}}, i};
  endfunction

  // Indirect target: base plus offset, lowest bit cleared.
  function automatic logic [XLEN-1:0] jump_target(input logic [XLEN-1:0] base,
                                                  input logic [IIMMW-1:0] i);
    logic [XLEN-1:0] sum;
    sum = base + sext_short(i);
    return {sum[XLEN-1:1], 1'b0};
  endfunction

  function automatic logic [XLEN-1:0] step_addr(input logic [XLEN-1:0] a,
                                                input int unsigned bytes);
    return a + XLEN'(bytes);
  endfunction

endpackage

// File: rtl/pcj_decode.sv
module pcj_decode
  import pcj_pkg::*;
(
  input  logic [31:0] instr_i,
  output fields_t     fields_o
);

  logic [6:0] opc;
  logic [2:0] f3;
  kind_e      kind;

  assign opc = instr_i[6:0];
  assign f3  = instr_i[14:12];

  always_comb begin
    kind = KIND_SEQ;
    if (opc == OPC_UPPER_PC) begin
      kind = KIND_UPC;
    end else if (opc == OPC_IND_JUMP && f3 == F3_IND_JUMP) begin
      kind = KIND_JUMP;
    end
  end

  always_comb begin
    fields_o.kind = kind;
    fields_o.rd   = instr_i[11:7];
    fields_o.rs1  = instr_i[19:15];
    fields_o.uimm = instr_i[31:12];
    fields_o.iimm = instr_i[31:20];
  end

endmodule

// File: rtl/pcj_exec.sv
module pcj_exec
  import pcj_pkg::*;
#(
  parameter int unsigned INSN_BYTES = 4
) (
  input  fields_t          fields_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [XLEN-1:0]  rs1_val_i,
  output logic [XLEN-1:0]  wdata_o,
  output logic             we_o,
  output logic             redirect_o,
  output logic [XLEN-1:0]  target_o,
  output logic             is_upc_o,
  output logic             is_jump_o
);

  logic [XLEN-1:0] upc_sum;
  logic [XLEN-1:0] link_addr;
  logic            rd_nonzero;

  assign is_upc_o   = (fields_i.kind == KIND_UPC);
  assign is_jump_o  = (fields_i.kind == KIND_JUMP);
  assign rd_nonzero = |fields_i.rd;

  // Both sums use the address of the executing instruction.
  assign upc_sum   = pc_i + upper_offset(fields_i.uimm);
  assign link_addr = step_addr(pc_i, INSN_BYTES);

  // Target is taken from the operand seen this cycle, whatever rd is.
  assign target_o   = jump_target(rs1_val_i, fields_i.iimm);
  assign redirect_o = is_jump_o;

  always_comb begin
    wdata_o = '0;
    we_o    = 1'b0;
    unique case (fields_i.kind)
      KIND_UPC: begin
        wdata_o = upc_sum;
        we_o    = rd_nonzero;
      end
      KIND_JUMP: begin
        wdata_o = link_addr;
        we_o    = rd_nonzero;
      end
      default: begin
        wdata_o = '0;
        we_o    = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/pcj_pc_reg.sv
module pcj_pc_reg
  import pcj_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_VEC  = 32'h0000_1000,
  parameter int unsigned     INSN_BYTES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             redirect_i,
  input  logic [XLEN-1:0]  target_i,
  output logic [XLEN-1:0]  pc_o,
  output logic [XLEN-1:0]  next_pc_o
);

  assign next_pc_o = redirect_i ? target_i : step_addr(pc_o, INSN_BYTES);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_o <= RESET_VEC;
    end else begin
      pc_o <= next_pc_o;
    end
  end

endmodule

// File: rtl/pcj_unit.sv
module pcj_unit
  import pcj_pkg::*;
#(
  parameter logic [31:0] RESET_VEC  = 32'h0000_1000,
  parameter int unsigned INSN_BYTES = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] instr_i,
  input  logic [31:0] rs1_val_i,
  output logic [31:0] pc_o,
  output logic [4:0]  rs1_idx_o,
  output logic [4:0]  rd_idx_o,
  output logic [31:0] rd_wdata_o,
  output logic        rd_we_o,
  output logic        redirect_o,
  output logic [31:0] target_o
);

  fields_t     fields;
  logic [31:0] pc_q;
  logic [31:0] next_pc;
  logic        is_upc;
  logic        is_jump;
  logic        redirect;
  logic [31:0] target;

  pcj_decode u_decode (
    .instr_i  (instr_i),
    .fields_o (fields)
  );

  pcj_exec #(.INSN_BYTES(INSN_BYTES)) u_exec (
    .fields_i   (fields),
    .pc_i       (pc_q),
    .rs1_val_i  (rs1_val_i),
    .wdata_o    (rd_wdata_o),
    .we_o       (rd_we_o),
    .redirect_o (redirect),
    .target_o   (target),
    .is_upc_o   (is_upc),
    .is_jump_o  (is_jump)
  );

  pcj_pc_reg #(.RESET_VEC(RESET_VEC), .INSN_BYTES(INSN_BYTES)) u_pc (
    .clk        (clk),
    .rst        (rst),
    .redirect_i (redirect),
    .target_i   (target),
    .pc_o       (pc_q),
    .next_pc_o  (next_pc)
  );

  assign pc_o       = pc_q;
  assign rs1_idx_o  = fields.rs1;
  assign rd_idx_o   = fields.rd;
  assign redirect_o = redirect;
  assign target_o   = target;

endmodule

// File: rtl/pcj_unit_checker.sv
module pcj_unit_checker (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc,
  input logic [4:0]  rd_idx,
  input logic [31:0] rd_wdata,
  input logic        rd_we,
  input logic        redirect,
  input logic [31:0] target,
  input logic        is_upc,
  input logic        is_jump
);

  AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    !redirect |=> pc == $past(pc) + 32'd4); // R6

  AST_REDIRECT_LOAD: assert property (@(posedge clk) disable iff (rst)
    redirect |=> pc == $past(target)); // R6

  AST_TARGET_EVEN: assert property (@(posedge clk) disable iff (rst)
    redirect |-> target[0] == 1'b0); // R3

  AST_X0_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    rd_idx == 5'd0 |-> !rd_we); // R5

  AST_UPC_NO_REDIRECT: assert property (@(posedge clk) disable iff (rst)
    is_upc |-> !redirect); // R2

  AST_LINK_VALUE: assert property (@(posedge clk) disable iff (rst)
    is_jump |-> rd_wdata == pc + 32'd4); // R4

  AST_SEQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    !is_upc && !is_jump |-> !rd_we && !redirect); // R7

endmodule

bind pcj_unit pcj_unit_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .pc       (pc_o),
  .rd_idx   (rd_idx_o),
  .rd_wdata (rd_wdata_o),
  .rd_we    (rd_we_o),
  .redirect (redirect_o),
  .target   (target_o),
  .is_upc   (is_upc),
  .is_jump  (is_jump)
);

// File: tb/pcj_unit_bench.sv
`timescale 1ns/1ps
module pcj_unit_bench;

  localparam logic [31:0] RV = 32'h0000_1000;
  localparam logic [31:0] NOP = 32'h0000_0013;

  typedef struct packed {
    logic [31:0] instr;
    logic [31:0] rs1;
  } vec_t;

  function automatic logic [31:0] mk_upc(input logic [19:0] imm, input logic [4:0] rd);
    return {imm, rd, 7'h17};
  endfunction

  function automatic logic [31:0] mk_jmp(input logic [11:0] imm, input logic [4:0] rs,
                                         input logic [2:0] f3, input logic [4:0] rd);
    return {imm, rs, f3, rd, 7'h67};
  endfunction

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{mk_upc(20'h12345, 5'd5),                 32'h0},
    '{mk_upc(20'h80000, 5'd1),                 32'h0},
    '{mk_upc(20'h00abc, 5'd0),                 32'h0},
    '{mk_jmp(12'h004, 5'd2, 3'd0, 5'd1),       32'h0000_1000},
    '{mk_jmp(12'hfff, 5'd3, 3'd0, 5'd2),       32'h0000_2000},
    '{mk_jmp(12'h001, 5'd4, 3'd0, 5'd0),       32'h0000_3000},
    '{NOP,                                     32'hdead_beef},
    '{mk_jmp(12'h010, 5'd5, 3'd1, 5'd6),       32'h0000_4000},
    '{mk_jmp(12'h008, 5'd7, 3'd0, 5'd7),       32'h0000_0400},
    '{mk_jmp(12'h7ff, 5'd8, 3'd0, 5'd3),       32'h8000_0000},
    '{mk_upc(20'hfffff, 5'd31),                32'h0},
    '{32'h0000_1037,                           32'h1234_5678},
    '{mk_jmp(12'h000, 5'd9, 3'd0, 5'd4),       32'hffff_fffd},
    '{mk_upc(20'h00000, 5'd6),                 32'h0},
    '{NOP,                                     32'h0}
  };

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] instr_i;
  logic [31:0] rs1_val_i;
  logic [31:0] pc_o;
  logic [4:0]  rs1_idx_o;
  logic [4:0]  rd_idx_o;
  logic [31:0] rd_wdata_o;
  logic        rd_we_o;
  logic        redirect_o;
  logic [31:0] target_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pcj_unit #(.RESET_VEC(RV)) u_pcj_unit (
    .clk(clk), .rst(rst), .instr_i(instr_i), .rs1_val_i(rs1_val_i),
    .pc_o(pc_o), .rs1_idx_o(rs1_idx_o), .rd_idx_o(rd_idx_o),
    .rd_wdata_o(rd_wdata_o), .rd_we_o(rd_we_o),
    .redirect_o(redirect_o), .target_o(target_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Reference model, written from the requirements.
  task automatic apply(input logic [31:0] ins, input logic [31:0] r1);
    logic [31:0] p, e_wd, e_tg, e_nx;
    logic        e_we, e_rd, up, jp;
    @(negedge clk);
    instr_i   = ins;
    rs1_val_i = r1;
    #1;
    p  = pc_o;
    up = (ins[6:0] == 7'h17);
    jp = (ins[6:0] == 7'h67) && (ins[14:12] == 3'd0);
    e_tg = (r1 + 32'($signed(ins) >>> 20)) & 32'hffff_fffe;
    e_wd = up ? p + (ins & 32'hffff_f000) : (jp ? p + 32'd4 : 32'h0);
    e_we = (up || jp) && (ins[11:7] != 5'd0);
    e_rd = jp;
    e_nx = jp ? e_tg : p + 32'd4;
    chk("R5", "rd_idx", 32'(rd_idx_o), 32'(ins[11:7]));
    chk("R5", "rd_we", 32'(rd_we_o), 32'(e_we));
    chk("R7", "redirect", 32'(redirect_o), 32'(e_rd));
    chk("R3", "rs1_idx", 32'(rs1_idx_o), 32'(ins[19:15]));
    if (up) chk("R2", "upper add", rd_wdata_o, e_wd);
    if (jp) begin
      chk("R4", "link", rd_wdata_o, e_wd);
      chk("R3", "target", target_o, e_tg);
      if (ins[11:7] == ins[19:15]) chk("R8", "rd==rs1 target", target_o, e_tg);
    end
    @(posedge clk);
    #1;
    chk(p == 32'hffff_fffc && !jp ? "R9" : "R6", "next pc", pc_o, e_nx);
  endtask

  initial begin
    rst = 1'b1;
    instr_i = NOP;
    rs1_val_i = 32'h0;
    repeat (2) @(posedge clk);
    #1;
    chk("R1", "reset pc", pc_o, RV);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].instr, VECS[i].rs1);
    end
    // R9: pc at 0x0 after wrap, one more sequential step
    chk("R9", "wrapped pc", pc_o, 32'h0000_0004);
    // R1: reset wins over a redirect in the same cycle
    @(negedge clk);
    instr_i   = mk_jmp(12'h000, 5'd1, 3'd0, 5'd1);
    rs1_val_i = 32'h0000_0500;
    rst       = 1'b1;
    @(posedge clk);
    #1;
    chk("R1", "reset over redirect", pc_o, RV);
    @(negedge clk);
    rst = 1'b0;
    instr_i = NOP;
    apply(mk_jmp(12'h800, 5'd10, 3'd0, 5'd10), 32'h0000_0900);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule